// File: doc/BRIEF.md
# Hierarchical QoS/CoS Queue Scheduler

This block picks, once per clock, the next class-of-service (CoS) queue that may send. The queues sit in a five-level tree. Each physical output port owns a group of logical ports. Each logical port owns a group of schedulers. Each scheduler owns a group of QoS queues. Each QoS queue is fed by a group of CoS queues. The block takes three inputs: one non-empty flag per CoS queue, one back-pressure line per physical port, and one mode bit per QoS queue. From these it produces a registered grant. The grant names the chosen CoS queue together with the physical port, logical port, scheduler and QoS queue it passed through.

The walk runs from the top of the tree downward. At each level it chooses one eligible child of the node chosen one level up. A node is eligible when at least one CoS queue below it holds data and its physical port is not back-pressured. The physical, logical, scheduler and QoS levels rotate among their eligible children in round-robin order. At the CoS level, each QoS queue uses either fixed priority or round robin, set by its mode bit.

The fan-out at every level is a power of two, so the index of any node holds the index of its parent in its upper bits. The default tree has 4 physical ports, 2 logical ports per physical port, 2 schedulers per logical port, 2 QoS queues per scheduler and 16 CoS queues per QoS queue, which gives 512 CoS queues.

Top module: `qos_tree_sched`

## Requirements
- R1: Indices are global and nest as follows: CoS queue c belongs to QoS queue c/16, QoS queue q to scheduler q/2, scheduler s to logical port s/2, and logical port l to physical port l/2. A grant always reports a path that is consistent with this nesting.
- R2: A physical port whose back-pressure bit is 1 is never granted. When every port that has traffic is back-pressured, grantValid is 0.
- R3: A grant only names a CoS queue whose non-empty flag was 1.
- R4: The grant is registered. The inputs present before clock edge N decide the grant outputs that are visible after edge N.
- R5: The physical level is round robin. After port p is granted, the search starts from port p+1 (modulo the port count) and takes the first eligible port in cyclic order.
- R6: Every logical-port, scheduler and QoS-queue node keeps its own round-robin pointer among its children, with the same rule as R5. A node's pointer moves only on cycles when the grant passes through that node.
- R7: When cosRrMode[q] is 0, the lowest-numbered non-empty CoS queue of QoS queue q wins.
- R8: When cosRrMode[q] is 1, the CoS queues of q are served in round robin, with the same rule as R5. The CoS pointer of q moves only on grants made while cosRrMode[q] is 1.
- R9: At most one grant is issued per cycle. grantValid is 1 exactly when, in the prior cycle, some non-empty CoS queue sat under a port that was not back-pressured.
- R10: During reset grantValid is 0, and every round-robin pointer restarts at index 0. The first grant after reset therefore takes the lowest eligible index at each level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cosNonEmpty | input | 512 | Non-empty flag per CoS queue (global index) |
| phyBackPressure | input | 4 | Back-pressure bit per physical port (1 = blocked) |
| cosRrMode | input | 32 | CoS selection mode per QoS queue (0 = fixed priority, 1 = round robin) |
| grantValid | output | 1 | A grant is issued this cycle |
| grantPhy | output | 2 | Granted physical port |
| grantLog | output | 3 | Granted logical port (global index) |
| grantSch | output | 4 | Granted scheduler (global index) |
| grantQos | output | 5 | Granted QoS queue (global index) |
| grantCos | output | 9 | Granted CoS queue (global index) |

## Verification
Every result of this block is due exactly one clock edge after the inputs that cause it. The grant register is the only stage between the input flags and the outputs, and the round-robin pointers update on that same edge. The driver sets inputs at a falling edge and runs a reference walk of the tree, including its own copy of the pointer state. It then queues the expected grant, tagged with the cycle number that follows the next rising edge. The monitor compares an entry at a falling edge only once the cycle counter reaches that tag, so the comparison always lands one edge after the stimulus, whatever order the two processes run in.

// File: rtl/qts_pkg.sv
package qts_pkg;
  // Tree shape; every fan-out must be a power of two, at least 2
  localparam int PHY_N       = 4;
  localparam int LOG_PER_PHY = 2;
  localparam int SCH_PER_LOG = 2;
  localparam int QOS_PER_SCH = 2;
  localparam int COS_PER_QOS = 16;

  localparam int LOG_N = PHY_N * LOG_PER_PHY;
  localparam int SCH_N = LOG_N * SCH_PER_LOG;
  localparam int QOS_N = SCH_N * QOS_PER_SCH;
  localparam int COS_N = QOS_N * COS_PER_QOS;

  localparam int PHY_W = $clog2(PHY_N);
  localparam int LOG_W = $clog2(LOG_N);
  localparam int SCH_W = $clog2(SCH_N);
  localparam int QOS_W = $clog2(QOS_N);
  localparam int COS_W = $clog2(COS_N);

  localparam int LLOC_W = $clog2(LOG_PER_PHY);
  localparam int SLOC_W = $clog2(SCH_PER_LOG);
  localparam int QLOC_W = $clog2(QOS_PER_SCH);
  localparam int CLOC_W = $clog2(COS_PER_QOS);

  typedef struct packed {
    logic [PHY_W-1:0] phy;
    logic [LOG_W-1:0] lg;
    logic [SCH_W-1:0] sch;
    logic [QOS_W-1:0] qos;
    logic [COS_W-1:0] cos;
  } path_t;

  typedef struct packed {
    logic commit;  // load a new grant and advance pointers
    logic idle;    // nothing eligible: drop grant valid
  } strobe_t;
endpackage

// File: rtl/qts_rr_pick.sv
module qts_rr_pick #(
  parameter int N = 2,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] ptr,
  input  logic         fixedPri,
  output logic [W-1:0] idx
);
  logic [W-1:0] base;
  int j;

  assign base = fixedPri ? '0 : ptr;

  // scan downward so the nearest request at or after base is the last write
  always_comb begin
    idx = '0;
    j   = 0;
    for (int k = N - 1; k >= 0; k--) begin
      j = (int'(base) + k) % N;
      if (req[j]) idx = W'(j);
    end
  end
endmodule

// File: rtl/qts_datapath.sv
module qts_datapath
  import qts_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [COS_N-1:0]          cosNonEmpty,
  input  logic [PHY_N-1:0]          phyBp,
  input  logic [QOS_N-1:0]          cosRrMode,
  input  logic [PHY_W-1:0]          phyPtr,
  input  logic [PHY_N*LLOC_W-1:0]   logPtr,
  input  logic [LOG_N*SLOC_W-1:0]   schPtr,
  input  logic [SCH_N*QLOC_W-1:0]   qosPtr,
  input  logic [QOS_N*CLOC_W-1:0]   cosPtr,
  input  strobe_t                   strobe,
  output logic                      pickValid,
  output logic [PHY_W-1:0]          pickPhy,
  output logic [LOG_W-1:0]          pickLog,
  output logic [SCH_W-1:0]          pickSch,
  output logic [QOS_W-1:0]          pickQos,
  output logic [CLOC_W-1:0]         pickCosLoc,
  output logic                      grantValid,
  output path_t                     grantPath
);
  logic [QOS_N-1:0] qosReq;
  logic [SCH_N-1:0] schReq;
  logic [LOG_N-1:0] logReq;
  logic [PHY_N-1:0] phyReq;

  logic [PHY_W-1:0]  phyIdx;
  logic [LLOC_W-1:0] logIdx [PHY_N];
  logic [SLOC_W-1:0] schIdx [LOG_N];
  logic [QLOC_W-1:0] qosIdx [SCH_N];
  logic [CLOC_W-1:0] cosIdx [QOS_N];

  // eligibility tree and one picker per node
  genvar g;
  generate
    for (g = 0; g < QOS_N; g++) begin : gQos
      assign qosReq[g] = |cosNonEmpty[g*COS_PER_QOS +: COS_PER_QOS];
      qts_rr_pick #(.N(COS_PER_QOS)) uPick (
        .req(cosNonEmpty[g*COS_PER_QOS +: COS_PER_QOS]),
        .ptr(cosPtr[g*CLOC_W +: CLOC_W]),
        .fixedPri(!cosRrMode[g]), .idx(cosIdx[g]));
    end
    for (g = 0; g < SCH_N; g++) begin : gSch
      assign schReq[g] = |qosReq[g*QOS_PER_SCH +: QOS_PER_SCH];
      qts_rr_pick #(.N(QOS_PER_SCH)) uPick (
        .req(qosReq[g*QOS_PER_SCH +: QOS_PER_SCH]),
        .ptr(qosPtr[g*QLOC_W +: QLOC_W]),
        .fixedPri(1'b0), .idx(qosIdx[g]));
    end
    for (g = 0; g < LOG_N; g++) begin : gLog
      assign logReq[g] = |schReq[g*SCH_PER_LOG +: SCH_PER_LOG];
      qts_rr_pick #(.N(SCH_PER_LOG)) uPick (
        .req(schReq[g*SCH_PER_LOG +: SCH_PER_LOG]),
        .ptr(schPtr[g*SLOC_W +: SLOC_W]),
        .fixedPri(1'b0), .idx(schIdx[g]));
    end
    for (g = 0; g < PHY_N; g++) begin : gPhy
      assign phyReq[g] = (|logReq[g*LOG_PER_PHY +: LOG_PER_PHY]) & ~phyBp[g];
      qts_rr_pick #(.N(LOG_PER_PHY)) uPick (
        .req(logReq[g*LOG_PER_PHY +: LOG_PER_PHY]),
        .ptr(logPtr[g*LLOC_W +: LLOC_W]),
        .fixedPri(1'b0), .idx(logIdx[g]));
    end
  endgenerate

  qts_rr_pick #(.N(PHY_N)) uPhyPick (
    .req(phyReq), .ptr(phyPtr), .fixedPri(1'b0), .idx(phyIdx));

  // walk down the chosen branch; parent index forms the upper bits
  assign pickValid  = |phyReq;
  assign pickPhy    = phyIdx;
  assign pickLog    = {pickPhy, logIdx[pickPhy]};
  assign pickSch    = {pickLog, schIdx[pickLog]};
  assign pickQos    = {pickSch, qosIdx[pickSch]};
  assign pickCosLoc = cosIdx[pickQos];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantPath  <= '0;
    end else if (strobe.commit) begin
      grantValid     <= 1'b1;
      grantPath.phy  <= pickPhy;
      grantPath.lg   <= pickLog;
      grantPath.sch  <= pickSch;
      grantPath.qos  <= pickQos;
      grantPath.cos  <= {pickQos, pickCosLoc};
    end else if (strobe.idle) begin
      grantValid <= 1'b0;
    end
  end
endmodule

// File: rtl/qts_control.sv
module qts_control
  import qts_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [QOS_N-1:0]         cosRrMode,
  input  logic                     pickValid,
  input  logic [PHY_W-1:0]         pickPhy,
  input  logic [LOG_W-1:0]         pickLog,
  input  logic [SCH_W-1:0]         pickSch,
  input  logic [QOS_W-1:0]         pickQos,
  input  logic [CLOC_W-1:0]        pickCosLoc,
  output logic [PHY_W-1:0]         phyPtr,
  output logic [PHY_N*LLOC_W-1:0]  logPtr,
  output logic [LOG_N*SLOC_W-1:0]  schPtr,
  output logic [SCH_N*QLOC_W-1:0]  qosPtr,
  output logic [QOS_N*CLOC_W-1:0]  cosPtr,
  output strobe_t                  strobe
);
  assign strobe.commit = pickValid;
  assign strobe.idle   = !pickValid;

  // only the nodes on the granted branch move past their granted child
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phyPtr <= '0;
      logPtr <= '0;
      schPtr <= '0;
      qosPtr <= '0;
      cosPtr <= '0;
    end else if (pickValid) begin
      phyPtr <= pickPhy + 1'b1;
      logPtr[pickPhy*LLOC_W +: LLOC_W] <= pickLog[LLOC_W-1:0] + 1'b1;
      schPtr[pickLog*SLOC_W +: SLOC_W] <= pickSch[SLOC_W-1:0] + 1'b1;
      qosPtr[pickSch*QLOC_W +: QLOC_W] <= pickQos[QLOC_W-1:0] + 1'b1;
      if (cosRrMode[pickQos])
        cosPtr[pickQos*CLOC_W +: CLOC_W] <= pickCosLoc + 1'b1;
    end
  end
endmodule

// File: rtl/qos_tree_sched.sv
module qos_tree_sched
  import qts_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [COS_N-1:0]   cosNonEmpty,
  input  logic [PHY_N-1:0]   phyBackPressure,
  input  logic [QOS_N-1:0]   cosRrMode,
  output logic               grantValid,
  output logic [PHY_W-1:0]   grantPhy,
  output logic [LOG_W-1:0]   grantLog,
  output logic [SCH_W-1:0]   grantSch,
  output logic [QOS_W-1:0]   grantQos,
  output logic [COS_W-1:0]   grantCos
);
  strobe_t                  strobe;
  path_t                    grantPath;
  logic                     pickValid;
  logic [PHY_W-1:0]         pickPhy;
  logic [LOG_W-1:0]         pickLog;
  logic [SCH_W-1:0]         pickSch;
  logic [QOS_W-1:0]         pickQos;
  logic [CLOC_W-1:0]        pickCosLoc;
  logic [PHY_W-1:0]         phyPtr;
  logic [PHY_N*LLOC_W-1:0]  logPtr;
  logic [LOG_N*SLOC_W-1:0]  schPtr;
  logic [SCH_N*QLOC_W-1:0]  qosPtr;
  logic [QOS_N*CLOC_W-1:0]  cosPtr;

  qts_control uCtrl (
    .clk, .rstN, .cosRrMode, .pickValid, .pickPhy, .pickLog, .pickSch,
    .pickQos, .pickCosLoc, .phyPtr, .logPtr, .schPtr, .qosPtr, .cosPtr,
    .strobe);

  qts_datapath uDp (
    .clk, .rstN, .cosNonEmpty, .phyBp(phyBackPressure), .cosRrMode,
    .phyPtr, .logPtr, .schPtr, .qosPtr, .cosPtr, .strobe, .pickValid,
    .pickPhy, .pickLog, .pickSch, .pickQos, .pickCosLoc, .grantValid,
    .grantPath);

  assign grantPhy = grantPath.phy;
  assign grantLog = grantPath.lg;
  assign grantSch = grantPath.sch;
  assign grantQos = grantPath.qos;
  assign grantCos = grantPath.cos;
endmodule

// File: rtl/qts_checker.sv
module qts_checker
  import qts_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [COS_N-1:0] cosNonEmpty,
  input logic [PHY_N-1:0] phyBackPressure,
  input logic             grantValid,
  input logic [PHY_W-1:0] grantPhy,
  input logic [LOG_W-1:0] grantLog,
  input logic [SCH_W-1:0] grantSch,
  input logic [QOS_W-1:0] grantQos,
  input logic [COS_W-1:0] grantCos
);
  localparam int PER_PHY = COS_N / PHY_N;

  logic [COS_N-1:0] cosQ;
  logic [PHY_N-1:0] bpQ;
  logic             anyElig, eligQ;

  always_comb begin
    anyElig = 1'b0;
    for (int p = 0; p < PHY_N; p++)
      if (!phyBackPressure[p] && (|cosNonEmpty[p*PER_PHY +: PER_PHY])) anyElig = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cosQ  <= '0;
      bpQ   <= '0;
      eligQ <= 1'b0;
    end else begin
      cosQ  <= cosNonEmpty;
      bpQ   <= phyBackPressure;
      eligQ <= anyElig;
    end
  end

  AST_NO_BLOCKED_PORT: assert property (@(posedge clk) disable iff (!rstN) grantValid |-> !bpQ[grantPhy]); // R2
  AST_GRANT_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN) grantValid |-> cosQ[grantCos]); // R3
  AST_PATH_NESTED: assert property (@(posedge clk) disable iff (!rstN) grantValid |-> (grantCos[COS_W-1:CLOC_W] == grantQos) && (grantQos[QOS_W-1:QLOC_W] == grantSch) && (grantSch[SCH_W-1:SLOC_W] == grantLog) && (grantLog[LOG_W-1:LLOC_W] == grantPhy)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN) !eligQ |-> !grantValid); // R9
  AST_WORK_CONSERVING: assert property (@(posedge clk) disable iff (!rstN) eligQ |-> grantValid); // R9
endmodule

bind qos_tree_sched qts_checker uChk (
  .clk(clk), .rstN(rstN), .cosNonEmpty(cosNonEmpty),
  .phyBackPressure(phyBackPressure), .grantValid(grantValid),
  .grantPhy(grantPhy), .grantLog(grantLog), .grantSch(grantSch),
  .grantQos(grantQos), .grantCos(grantCos));

// File: tb/qos_tree_sched_tb.sv
module qos_tree_sched_tb;
  import qts_pkg::*;

  localparam int CPP = COS_N / PHY_N;
  localparam int CPL = COS_N / LOG_N;
  localparam int CPS = COS_N / SCH_N;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rstN;
  logic [COS_N-1:0] cosIn;
  logic [PHY_N-1:0] bpIn;
  logic [QOS_N-1:0] modeIn;
  logic             grantValid;
  logic [PHY_W-1:0] grantPhy;
  logic [LOG_W-1:0] grantLog;
  logic [SCH_W-1:0] grantSch;
  logic [QOS_W-1:0] grantQos;
  logic [COS_W-1:0] grantCos;

  qos_tree_sched u_dut (
    .clk(clk), .rstN(rstN), .cosNonEmpty(cosIn), .phyBackPressure(bpIn),
    .cosRrMode(modeIn), .grantValid(grantValid), .grantPhy(grantPhy),
    .grantLog(grantLog), .grantSch(grantSch), .grantQos(grantQos),
    .grantCos(grantCos));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    int    due;
    bit    v;
    int    p, l, s, q, c;
    string tag;
  } exp_t;
  exp_t sb[$];

  // reference pointer state
  int mPhy;
  int mLog [PHY_N];
  int mSch [LOG_N];
  int mQos [SCH_N];
  int mCos [QOS_N];

  function automatic bit anyBits(int lo, int len);
    for (int i = lo; i < lo + len; i++) if (cosIn[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int pickRr(bit [15:0] r, int n, int start);
    for (int k = 0; k < n; k++) begin
      int jj;
      jj = (start + k) % n;
      if (r[jj]) return jj;
    end
    return -1;
  endfunction

  task automatic step(string tag);
    exp_t e;
    bit [15:0] r;
    int k;
    e.due = cyc + 1; e.tag = tag; e.v = 1'b0;
    e.p = 0; e.l = 0; e.s = 0; e.q = 0; e.c = 0;
    r = '0;
    for (int p = 0; p < PHY_N; p++) r[p] = anyBits(p*CPP, CPP) && !bpIn[p];
    k = pickRr(r, PHY_N, mPhy);
    if (k >= 0) begin
      e.v = 1'b1; e.p = k; mPhy = (k + 1) % PHY_N;
      r = '0;
      for (int j = 0; j < LOG_PER_PHY; j++) r[j] = anyBits((e.p*LOG_PER_PHY + j)*CPL, CPL);
      k = pickRr(r, LOG_PER_PHY, mLog[e.p]); mLog[e.p] = (k + 1) % LOG_PER_PHY;
      e.l = e.p*LOG_PER_PHY + k;
      r = '0;
      for (int j = 0; j < SCH_PER_LOG; j++) r[j] = anyBits((e.l*SCH_PER_LOG + j)*CPS, CPS);
      k = pickRr(r, SCH_PER_LOG, mSch[e.l]); mSch[e.l] = (k + 1) % SCH_PER_LOG;
      e.s = e.l*SCH_PER_LOG + k;
      r = '0;
      for (int j = 0; j < QOS_PER_SCH; j++) r[j] = anyBits((e.s*QOS_PER_SCH + j)*COS_PER_QOS, COS_PER_QOS);
      k = pickRr(r, QOS_PER_SCH, mQos[e.s]); mQos[e.s] = (k + 1) % QOS_PER_SCH;
      e.q = e.s*QOS_PER_SCH + k;
      r = '0;
      for (int j = 0; j < COS_PER_QOS; j++) r[j] = cosIn[e.q*COS_PER_QOS + j];
      if (modeIn[e.q]) begin
        k = pickRr(r, COS_PER_QOS, mCos[e.q]); mCos[e.q] = (k + 1) % COS_PER_QOS;
      end else begin
        k = pickRr(r, COS_PER_QOS, 0);
      end
      e.c = e.q*COS_PER_QOS + k;
    end
    sb.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compare each expectation at the cycle it is due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      nChecks++;
      if (grantValid !== e.v ||
          (e.v && (int'(grantCos) != e.c || int'(grantQos) != e.q || int'(grantSch) != e.s ||
                   int'(grantLog) != e.l || int'(grantPhy) != e.p))) begin
        nFails++;
        $display("FAIL %s cyc=%0d: got v=%0b p=%0d l=%0d s=%0d q=%0d c=%0d expected v=%0b p=%0d l=%0d s=%0d q=%0d c=%0d",
                 e.tag, cyc, grantValid, grantPhy, grantLog, grantSch, grantQos, grantCos,
                 e.v, e.p, e.l, e.s, e.q, e.c);
      end
    end
  end

  bit done = 1'b0;

  initial begin
    #(200000 * 4);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int sp;
    mPhy = 0;
    foreach (mLog[i]) mLog[i] = 0;
    foreach (mSch[i]) mSch[i] = 0;
    foreach (mQos[i]) mQos[i] = 0;
    foreach (mCos[i]) mCos[i] = 0;
    cosIn = '0; bpIn = '0; modeIn = '0; rstN = 1'b0;
    repeat (3) @(negedge clk);
    nChecks++;
    if (grantValid !== 1'b0) begin
      nFails++;
      $display("FAIL R10 reset: got v=%0b expected v=0", grantValid);
    end
    rstN = 1'b1;

    repeat (3) step("R9 empty");
    // R10: first grant after reset takes index 0 at every level
    cosIn = '1;
    repeat (40) step("R10 R5 R6 R7 full fixed priority");
    cosIn = '0; cosIn[300] = 1'b1;
    repeat (4) step("R1 R3 R4 single queue");
    modeIn = '1; cosIn = '1;
    repeat (600) step("R8 R6 full round robin");
    bpIn = 4'b1010;
    repeat (20) step("R2 partial back-pressure");
    bpIn = '1;
    repeat (5) step("R2 R9 all back-pressured");
    bpIn = '0; cosIn = '0;
    repeat (3) step("R9 drained");

    repeat (500) begin
      sp = 2 + int'($urandom % 40);
      for (int i = 0; i < COS_N; i++) cosIn[i] = ($urandom % sp == 0);
      for (int i = 0; i < QOS_N; i++) modeIn[i] = 1'($urandom % 2);
      bpIn = ($urandom % 3 == 0) ? PHY_N'($urandom) : '0;
      repeat (4) step("R1 R2 R3 R5 R6 R7 R8 R9 random");
    end

    cosIn = '0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule